// File: doc/BRIEF.md
# External Interrupt Pending and Enable Unit

This unit collects external interrupt events for one processor and reduces them to a single request. Agents on the system bus raise an event by writing an interrupt number to the unit's one word. Software on the local core acknowledges events by clearing bits in the pending register, and it chooses which events may interrupt by writing an enable mask. A timer alarm input raises interrupt number 0 through the same path a bus write uses.

Interrupt numbers are counted from the most significant end. The number comes from the low bits of the bus write data. Number 0 maps to pending bit 31 and number 31 maps to bit 0. The request line is high whenever a pending bit is also enabled. A one-cycle take strobe fires only when three things are true in that cycle: the request line is high, the processor's interrupt-enable status bit is set, and the core reports that it can accept an interruption.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A bus write with `bus_bytes` = 4 sets the single pending bit at index 31 minus `bus_wdata[4:0]`. Data bits above bit 4 have no effect.
- R2: A bus write only adds pending bits. Bits that are already set stay set.
- R3: A bus read with `bus_bytes` = 4 raises `bus_rvalid` on the following cycle, and `bus_rdata` then holds the pending register.
- R4: A bus access whose `bus_bytes` is not 4 is ignored. A write of that kind sets no bit, and a read of that kind raises no `bus_rvalid`.
- R5: A software clear write (`sw_clr_en`) clears every pending bit that is 1 in `sw_data` and leaves every other bit unchanged.
- R6: A software mask write (`sw_mask_en`) replaces the whole enable mask with `sw_data`.
- R7: `irq_req` equals the OR of (pending AND mask). It changes at the same clock edge that updates either register.
- R8: An `alarm` pulse sets pending bit 31, exactly as a bus write of data 0 does. It can coincide with a bus write, and then both bits are set.
- R9: `take_irq` rises one cycle after a cycle in which `irq_req`, `psw_ien` and `core_ready` were all high. In any other case it stays low.
- R10: `take_irq` is never high for two consecutive cycles.
- R11: If a bus or alarm set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R12: Synchronous reset clears the pending register, the mask, `irq_req`, `take_irq` and `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_bytes | input | 3 | Access size in bytes; only 4 is accepted |
| bus_wdata | input | 32 | Bus write data; low 5 bits give the interrupt number |
| bus_rdata | output | 32 | Pending register, captured by an accepted read |
| bus_rvalid | output | 1 | High for one cycle after an accepted read |
| sw_clr_en | input | 1 | Software write-one-to-clear of the pending register |
| sw_mask_en | input | 1 | Software write of the enable mask |
| sw_data | input | 32 | Data for the software writes |
| alarm | input | 1 | Timer alarm pulse, raises interrupt number 0 |
| psw_ien | input | 1 | Processor interrupt-enable status bit |
| core_ready | input | 1 | Core can accept an interruption this cycle |
| irq_req | output | 1 | Level request: some enabled bit is pending |
| take_irq | output | 1 | One-cycle strobe to take the interrupt |

## Verification
The assertions assume that the pending register changes only through its inputs. A bit may drop only in a cycle with a software clear, and an accepted bus write must leave its decoded bit set on the next cycle. The assertions also assume that a bus access lasts exactly one cycle, so the size and data they sample with `$past` belong to that same access. The stimulus follows these rules: each task raises `bus_valid` for one cycle only, changes inputs on the falling edge, and returns every strobe low before the next scenario. The set-versus-clear collision is the one case where two writers are driven in the same cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  // Default geometry of the unit
  localparam int unsigned DEF_LINES  = 32;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned BYTES_W    = 3;

  // Classification of one bus cycle
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/eirq_bus_port.sv
module eirq_bus_port
  import eirq_pkg::*;
#(
  parameter int unsigned LINES  = DEF_LINES,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [BYTES_W-1:0] bus_bytes,
  input  logic [LINES-1:0]   pend_q,
  output logic               wr_ok,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid
);
  localparam int unsigned WORD_BYTES = DATA_W / 8;

  acc_kind_e kind;

  always_comb begin
    if (!bus_valid)                               kind = ACC_IDLE;
    else if (bus_bytes != BYTES_W'(WORD_BYTES))   kind = ACC_BAD;
    else if (bus_write)                           kind = ACC_WRITE;
    else                                          kind = ACC_READ;
  end

  assign wr_ok = (kind == ACC_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= (kind == ACC_READ);
      if (kind == ACC_READ)
        bus_rdata <= DATA_W'(pend_q);
    end
  end
endmodule

// File: rtl/eirq_set_dec.sv
module eirq_set_dec #(
  parameter int unsigned LINES = 32
) (
  input  logic                     wr_ok,
  input  logic [$clog2(LINES)-1:0] num,
  input  logic                     alarm,
  output logic [LINES-1:0]         set_vec
);
  localparam int unsigned IDX_W = $clog2(LINES);

  logic [IDX_W-1:0] bit_idx;
  assign bit_idx = ~num;  // number 0 -> top bit

  for (genvar i = 0; i < LINES; i++) begin : g_bit
    if (i == LINES - 1) begin : g_top
      assign set_vec[i] = (wr_ok && bit_idx == IDX_W'(i)) || alarm;
    end else begin : g_rest
      assign set_vec[i] = wr_ok && bit_idx == IDX_W'(i);
    end
  end
endmodule

// File: rtl/eirq_pend_reg.sv
module eirq_pend_reg #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] set_vec,
  input  logic             clr_en,
  input  logic [LINES-1:0] clr_vec,
  output logic [LINES-1:0] pend_d,
  output logic [LINES-1:0] pend_q
);
  logic [LINES-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_vec : '0;
  // set applied after clear: a colliding event survives
  assign pend_d  = (pend_q & ~clr_eff) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/eirq_req_gen.sv
module eirq_req_gen #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pend_d,
  input  logic             mask_en,
  input  logic [LINES-1:0] mask_data,
  input  logic             psw_ien,
  input  logic             core_ready,
  output logic [LINES-1:0] mask_q,
  output logic             irq_req,
  output logic             take_irq
);
  logic [LINES-1:0] mask_d;

  assign mask_d = mask_en ? mask_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      irq_req  <= 1'b0;
      take_irq <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      irq_req  <= |(pend_d & mask_d);
      take_irq <= irq_req && psw_ien && core_ready && !take_irq;
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned LINES  = DEF_LINES,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [BYTES_W-1:0] bus_bytes,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  input  logic               sw_clr_en,
  input  logic               sw_mask_en,
  input  logic [LINES-1:0]   sw_data,
  input  logic               alarm,
  input  logic               psw_ien,
  input  logic               core_ready,
  output logic               irq_req,
  output logic               take_irq
);
  localparam int unsigned IDX_W = $clog2(LINES);

  logic             wr_ok;
  logic [LINES-1:0] set_vec;
  logic [LINES-1:0] pend_d;
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] mask_q;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:IDX_W];

  eirq_bus_port #(.LINES(LINES), .DATA_W(DATA_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_bytes  (bus_bytes),
    .pend_q     (pend_q),
    .wr_ok      (wr_ok),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  eirq_set_dec #(.LINES(LINES)) u_dec (
    .wr_ok   (wr_ok),
    .num     (bus_wdata[IDX_W-1:0]),
    .alarm   (alarm),
    .set_vec (set_vec)
  );

  eirq_pend_reg #(.LINES(LINES)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_en  (sw_clr_en),
    .clr_vec (sw_data),
    .pend_d  (pend_d),
    .pend_q  (pend_q)
  );

  eirq_req_gen #(.LINES(LINES)) u_req (
    .clk        (clk),
    .rst        (rst),
    .pend_d     (pend_d),
    .mask_en    (sw_mask_en),
    .mask_data  (sw_data),
    .psw_ien    (psw_ien),
    .core_ready (core_ready),
    .mask_q     (mask_q),
    .irq_req    (irq_req),
    .take_irq   (take_irq)
  );
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
  parameter int unsigned LINES = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic [2:0]               bus_bytes,
  input logic [$clog2(LINES)-1:0] bus_num,
  input logic                     sw_clr_en,
  input logic                     alarm,
  input logic                     psw_ien,
  input logic                     core_ready,
  input logic [LINES-1:0]         pend_q,
  input logic [LINES-1:0]         mask_q,
  input logic                     irq_req,
  input logic                     take_irq
);
  // R1: accepted write leaves its decoded bit set
  a_r1_bus_sets_bit: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_bytes == 3'd4)
      |=> pend_q[LINES - 1 - int'($past(bus_num))]);

  // R2: without a software clear no pending bit drops
  a_r2_no_bus_clear: assert property (@(posedge clk) disable iff (rst)
    !sw_clr_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R4: wrong-size write with no other writer leaves pending unchanged
  a_r4_bad_size_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_bytes != 3'd4 && !alarm && !sw_clr_en)
      |=> $stable(pend_q));

  // R7: request tracks enabled pending bits
  a_r7_req_level: assert property (@(posedge clk) disable iff (rst)
    irq_req == |(pend_q & mask_q));

  // R9: take only after request, enable and readiness
  a_r9_take_cond: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(irq_req && psw_ien && core_ready));

  // R10: single-cycle strobe
  a_r10_take_pulse: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq);

  // R12: reset leaves everything idle
  a_r12_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (pend_q == '0 && mask_q == '0 && !irq_req && !take_irq));
endmodule

bind ext_irq_ctrl eirq_chk #(.LINES(LINES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_bytes  (bus_bytes),
  .bus_num    (bus_wdata[$clog2(LINES)-1:0]),
  .sw_clr_en  (sw_clr_en),
  .alarm      (alarm),
  .psw_ien    (psw_ien),
  .core_ready (core_ready),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .irq_req    (irq_req),
  .take_irq   (take_irq)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_bytes = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sw_clr_en = 1'b0, sw_mask_en = 1'b0;
  logic [31:0] sw_data = '0;
  logic        alarm = 1'b0, psw_ien = 1'b0, core_ready = 1'b0;
  logic        irq_req, take_irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] pend_m = '0;
  logic [31:0] mask_m = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_bytes(bus_bytes), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .sw_clr_en(sw_clr_en), .sw_mask_en(sw_mask_en),
    .sw_data(sw_data), .alarm(alarm), .psw_ien(psw_ien),
    .core_ready(core_ready), .irq_req(irq_req), .take_irq(take_irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [31:0] d, input logic [2:0] nb);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = d; bus_bytes = nb;
    step();
    bus_valid = 1'b0; bus_write = 1'b0; bus_bytes = 3'd4;
    if (nb == 3'd4) pend_m[31 - d[4:0]] = 1'b1;
  endtask

  task automatic bus_rd(input logic [2:0] nb, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_bytes = nb;
    step();
    bus_valid = 1'b0; bus_bytes = 3'd4;
    if (nb == 3'd4) begin
      check(bus_rvalid === 1'b1, tag, 32'(bus_rvalid), 32'd1);
      check(bus_rdata === pend_m, tag, bus_rdata, pend_m);
    end else begin
      check(bus_rvalid === 1'b0, tag, 32'(bus_rvalid), 32'd0);
    end
  endtask

  task automatic sw_clr(input logic [31:0] v);
    @(negedge clk);
    sw_clr_en = 1'b1; sw_data = v;
    step();
    sw_clr_en = 1'b0;
    pend_m &= ~v;
  endtask

  task automatic sw_mask(input logic [31:0] v);
    @(negedge clk);
    sw_mask_en = 1'b1; sw_data = v;
    step();
    sw_mask_en = 1'b0;
    mask_m = v;
  endtask

  task automatic check_req(input string tag);
    check(irq_req === (|(pend_m & mask_m)), tag, 32'(irq_req),
          32'(|(pend_m & mask_m)));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    pend_m = '0; mask_m = '0;
    check(irq_req === 1'b0 && take_irq === 1'b0, "R12 outputs idle",
          {30'd0, irq_req, take_irq}, 32'd0);
    bus_rd(3'd4, "R12 pending cleared");
    sw_clr('0);
    bus_wr(32'd2, 3'd4);
    check_req("R12 mask cleared, no request");
  endtask

  task automatic t_bus_set();
    bus_wr(32'd0, 3'd4);
    bus_rd(3'd4, "R1 number 0 -> bit 31");
    bus_wr(32'hFFFF_FFE0 | 32'd31, 3'd4);
    bus_rd(3'd4, "R1 number 31 -> bit 0, upper data ignored");
    bus_wr(32'h0000_0109, 3'd4);
    bus_rd(3'd4, "R2 write ORs, earlier bits kept");
    bus_rd(3'd4, "R3 read returns pending");
  endtask

  task automatic t_size();
    bus_wr(32'd4, 3'd2);
    bus_wr(32'd6, 3'd1);
    bus_rd(3'd4, "R4 short writes set nothing");
    bus_rd(3'd2, "R4 short read gives no response");
  endtask

  task automatic t_clear();
    bus_wr(32'd12, 3'd4);
    sw_clr(32'h8000_0001);
    bus_rd(3'd4, "R5 ones cleared, others kept");
    sw_clr(32'h0000_0000);
    bus_rd(3'd4, "R5 zero write changes nothing");
  endtask

  task automatic t_mask();
    sw_mask(32'h0000_0100);
    check_req("R6 mask on bit 8 (unset)");
    sw_mask(32'h0008_0000);
    check_req("R6 mask replaced, bit 19 pending");
    check(irq_req === 1'b1, "R7 request high", 32'(irq_req), 32'd1);
    sw_clr(32'h0008_0000);
    check(irq_req === 1'b0, "R7 request drops at clear edge", 32'(irq_req), 32'd0);
    bus_wr(32'd12, 3'd4);
    check(irq_req === 1'b1, "R7 request rises at set edge", 32'(irq_req), 32'd1);
  endtask

  task automatic t_alarm();
    sw_clr(32'hFFFF_FFFF);
    sw_mask(32'h8000_0000);
    @(negedge clk); alarm = 1'b1;
    step();
    alarm = 1'b0; pend_m[31] = 1'b1;
    check(irq_req === 1'b1, "R8 alarm raises number 0", 32'(irq_req), 32'd1);
    bus_rd(3'd4, "R8 alarm sets bit 31");
    sw_clr(32'hFFFF_FFFF);
    @(negedge clk);
    alarm = 1'b1; bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = 32'd7;
    step();
    alarm = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    pend_m[31] = 1'b1; pend_m[24] = 1'b1;
    bus_rd(3'd4, "R8 alarm with bus write sets both");
  endtask

  task automatic t_take();
    sw_mask(32'hFFFF_FFFF);
    @(negedge clk); psw_ien = 1'b0; core_ready = 1'b1;
    step();
    check(take_irq === 1'b0, "R9 no take with enable low", 32'(take_irq), 32'd0);
    psw_ien = 1'b1;
    step();
    check(take_irq === 1'b1, "R9 take after all conditions", 32'(take_irq), 32'd1);
    step();
    check(take_irq === 1'b0, "R10 strobe lasts one cycle", 32'(take_irq), 32'd0);
    core_ready = 1'b0;
    step();
    check(take_irq === 1'b0, "R9 no take when core not ready", 32'(take_irq), 32'd0);
    core_ready = 1'b1;
    sw_clr(32'hFFFF_FFFF);
    step();
    check(take_irq === 1'b0, "R9 no take without request", 32'(take_irq), 32'd0);
    psw_ien = 1'b0; core_ready = 1'b0;
  endtask

  task automatic t_collide();
    bus_wr(32'd5, 3'd4);
    bus_wr(32'd28, 3'd4);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = 32'd5;
    sw_clr_en = 1'b1; sw_data = 32'hFFFF_FFFF;
    step();
    bus_valid = 1'b0; bus_write = 1'b0; sw_clr_en = 1'b0;
    pend_m = 32'h0400_0000;
    bus_rd(3'd4, "R11 set wins over clear");
  endtask

  initial begin
    t_reset();
    t_bus_set();
    t_size();
    t_clear();
    t_mask();
    t_alarm();
    t_take();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule